// File: doc/BRIEF.md
# Cross-Clock Single-Word Mailbox

This block moves one data word at a time from a sending clock domain to a receiving clock domain. It sits beside a FIFO and does not use it. The sender offers a word with a valid/ready handshake. The word is captured in a holding register, and the sender's ready drops on that same edge. The receiver later sees the word flagged as waiting, reads it, and that read frees the register for the next word.

Control crosses between the domains as two toggle signals, each passed through a short chain of flip-flops. The data itself is not synchronised. It is held constant from the write until the sender learns of the read, so the receiver can sample it directly.

Back-pressure rules:
- The sender may hold `snd_valid` high for any number of cycles. A word is taken only on an edge where `snd_ready` is high.
- The receiver may leave a waiting word unread for as long as it likes. The word and its flag stay as they are until a read.
- A read while no word is waiting does nothing.

An active-low flag in the receiver domain mirrors the waiting state for logic that expects a "mailbox full" indication.

Top module: `mailbox_xfer`

## Requirements
- R1: While and after `rst_n` is low, with no transfer since reset, `snd_ready` is 1, `rcv_valid` is 0 and `rcv_full_n` is 1.
- R2: A rising `snd_clk` edge with `snd_valid` and `snd_ready` both high stores `snd_data` and drives `snd_ready` low right after that edge.
- R3: While `snd_ready` is low, `snd_valid` has no effect. The stored word and the flags stay as they are.
- R4: `rcv_valid` rises, and `rcv_full_n` falls, on the SYNC_STAGES-th rising `rcv_clk` edge after the write edge (2 with default parameters).
- R5: While `rcv_valid` is high, `rcv_data` equals the last accepted word. While `rcv_ready` is low, the word stays waiting.
- R6: A rising `rcv_clk` edge with `rcv_valid` and `rcv_ready` both high drives `rcv_valid` low and `rcv_full_n` high right after that edge.
- R7: `snd_ready` returns high on the SYNC_STAGES-th rising `snd_clk` edge after the read edge. It never does so while the word is still waiting.
- R8: `rcv_ready` held high while no word waits does not change `snd_ready`, `rcv_valid` or later transfers.
- R9: Asserting `rst_n` in the middle of a transfer discards the word at once: `rcv_full_n` goes to 1 and `snd_ready` goes to 1.
- R10: `rcv_full_n` is always the inverse of `rcv_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sender domain clock |
| rcv_clk | input | 1 | Receiver domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| snd_valid | input | 1 | Sender offers a word |
| snd_ready | output | 1 | Register free; an offered word is taken on this edge |
| snd_data | input | WIDTH (36) | Word to send |
| rcv_valid | output | 1 | A word is waiting for the receiver |
| rcv_ready | input | 1 | Receiver reads the waiting word |
| rcv_data | output | WIDTH (36) | Held word |
| rcv_full_n | output | 1 | Active-low mailbox-full flag, receiver domain |

## Verification
Results are due at fixed edge counts:
- `snd_ready` falls right after the write edge.
- `rcv_valid` rises two receiver edges later.
- `rcv_valid` falls right after the read edge.
- `snd_ready` rises two sender edges after the read edge.

The bench counts edges in the relevant domain from the triggering edge until the output changes, and compares the count with the requirement. It samples a fixed 0.2 ns after each edge. The two clocks are phased so that their edges are always at least 0.5 ns apart, which keeps every sample clear of the other domain's edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_WIDTH_DEF = 36;
  localparam int unsigned MBX_SYNC_DEF  = 2;

  // Two toggle phases differ when one event is outstanding.
  function automatic logic phase_differs(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_send.sv
module mbx_send #(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             ack_phase,
  output logic             req_phase,
  output logic [WIDTH-1:0] word_q
);
  import mbx_pkg::*;

  logic fire;

  // Free when every request has been acknowledged.
  assign in_ready = ~phase_differs(req_phase, ack_phase);
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_phase <= 1'b0;
      word_q    <= '0;
    end else if (fire) begin
      req_phase <= ~req_phase;
      word_q    <= in_data;
    end
  end
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv (
  input  logic clk,
  input  logic rst_n,
  input  logic req_phase,
  input  logic out_ready,
  output logic out_valid,
  output logic ack_phase
);
  import mbx_pkg::*;

  assign out_valid = phase_differs(req_phase, ack_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ack_phase <= 1'b0;
    else if (out_valid && out_ready) ack_phase <= ~ack_phase;
  end
endmodule

// File: rtl/mailbox_xfer.sv
module mailbox_xfer #(
  parameter int unsigned WIDTH       = mbx_pkg::MBX_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = mbx_pkg::MBX_SYNC_DEF
) (
  input  logic             snd_clk,
  input  logic             rcv_clk,
  input  logic             rst_n,
  input  logic             snd_valid,
  output logic             snd_ready,
  input  logic [WIDTH-1:0] snd_data,
  output logic             rcv_valid,
  input  logic             rcv_ready,
  output logic [WIDTH-1:0] rcv_data,
  output logic             rcv_full_n
);
  localparam int unsigned STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic req_phase, req_phase_rcv;
  logic ack_phase, ack_phase_snd;
  logic [WIDTH-1:0] word_q;

  mbx_send #(.WIDTH(WIDTH)) u_send (
    .clk       (snd_clk),
    .rst_n     (rst_n),
    .in_valid  (snd_valid),
    .in_data   (snd_data),
    .in_ready  (snd_ready),
    .ack_phase (ack_phase_snd),
    .req_phase (req_phase),
    .word_q    (word_q)
  );

  mbx_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (rcv_clk),
    .rst_n (rst_n),
    .d     (req_phase),
    .q     (req_phase_rcv)
  );

  mbx_recv u_recv (
    .clk       (rcv_clk),
    .rst_n     (rst_n),
    .req_phase (req_phase_rcv),
    .out_ready (rcv_ready),
    .out_valid (rcv_valid),
    .ack_phase (ack_phase)
  );

  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (snd_clk),
    .rst_n (rst_n),
    .d     (ack_phase),
    .q     (ack_phase_snd)
  );

  // Word is held stable until the acknowledgement returns, so no sync here.
  assign rcv_data   = word_q;
  assign rcv_full_n = ~rcv_valid;
endmodule

// File: rtl/mailbox_xfer_chk.sv
module mailbox_xfer_chk #(
  parameter int unsigned WIDTH = 36
) (
  input logic             snd_clk,
  input logic             rcv_clk,
  input logic             rst_n,
  input logic             snd_valid,
  input logic             snd_ready,
  input logic [WIDTH-1:0] rcv_data,
  input logic             rcv_valid,
  input logic             rcv_ready
);
  // R2
  accept_blocks_chk: assert property (@(posedge snd_clk) disable iff (!rst_n)
    snd_valid && snd_ready |=> !snd_ready);

  // R3
  busy_word_stable_chk: assert property (@(posedge snd_clk) disable iff (!rst_n)
    !snd_ready |=> $stable(rcv_data));

  // R5
  waiting_holds_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    rcv_valid && !rcv_ready |=> rcv_valid && $stable(rcv_data));

  // R6
  read_clears_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    rcv_valid && rcv_ready |=> !rcv_valid);

  // R7
  no_early_free_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    rcv_valid |-> !snd_ready);
endmodule

bind mailbox_xfer mailbox_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .snd_clk   (snd_clk),
  .rcv_clk   (rcv_clk),
  .rst_n     (rst_n),
  .snd_valid (snd_valid),
  .snd_ready (snd_ready),
  .rcv_data  (rcv_data),
  .rcv_valid (rcv_valid),
  .rcv_ready (rcv_ready)
);

// File: tb/sim_mailbox_xfer.sv
`timescale 1ns/100ps
module sim_mailbox_xfer;
  localparam int W    = 36;
  localparam int SYNC = 2;

  logic snd_clk = 1'b0;
  logic rcv_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic snd_valid = 1'b0;
  logic rcv_ready = 1'b0;
  logic [W-1:0] snd_data = '0;
  logic snd_ready, rcv_valid, rcv_full_n;
  logic [W-1:0] rcv_data;

  int checks = 0;
  int errors = 0;

  mailbox_xfer #(.WIDTH(W), .SYNC_STAGES(SYNC)) u0 (
    .snd_clk(snd_clk), .rcv_clk(rcv_clk), .rst_n(rst_n),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
    .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_data(rcv_data),
    .rcv_full_n(rcv_full_n)
  );

  // 50 MHz sender clock; receiver edges sit 0.5 ns or more away from it.
  always #10 snd_clk = ~snd_clk;
  initial begin
    #3.5;
    forever begin
      rcv_clk = ~rcv_clk;
      #7;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] d);
    @(posedge snd_clk); #0.2;
    snd_valid = 1'b1;
    snd_data  = d;
    @(posedge snd_clk); #0.2;
    snd_valid = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge rcv_clk); #0.2;
      n++;
      if (rcv_valid) break;
    end
  endtask

  task automatic read_and_count(output int n);
    @(posedge rcv_clk); #0.2;
    rcv_ready = 1'b1;
    @(posedge rcv_clk); #0.2;
    rcv_ready = 1'b0;
    check(rcv_valid == 1'b0 && rcv_full_n == 1'b1, "R6 flag after read",
          {62'b0, rcv_valid, rcv_full_n}, 64'h1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge snd_clk); #0.2;
      n++;
      if (snd_ready) break;
    end
  endtask

  task automatic t_reset;
    #1;
    check(snd_ready == 1'b1, "R1 snd_ready in reset", 64'(snd_ready), 64'h1);
    check(rcv_valid == 1'b0 && rcv_full_n == 1'b1, "R1 flag in reset",
          {62'b0, rcv_valid, rcv_full_n}, 64'h1);
    #54.1;
    rst_n = 1'b1;
    #20;
    check(snd_ready == 1'b1 && rcv_full_n == 1'b1, "R1 after release",
          {62'b0, snd_ready, rcv_full_n}, 64'h3);
  endtask

  task automatic t_xfer(input logic [W-1:0] d);
    int n;
    send_word(d);
    check(snd_ready == 1'b0, "R2 ready drops on write", 64'(snd_ready), 64'h0);
    wait_valid(n);
    check(n == SYNC, "R4 receiver edges to valid", 64'(n), 64'(SYNC));
    check(rcv_full_n == ~rcv_valid, "R10 flag polarity",
          64'(rcv_full_n), 64'(~rcv_valid));
    check(rcv_data == d, "R5 data delivered", 64'(rcv_data), 64'(d));
    for (int i = 0; i < 3; i++) begin
      @(posedge rcv_clk); #0.2;
    end
    check(rcv_valid == 1'b1 && rcv_data == d, "R5 word held while unread",
          64'(rcv_data), 64'(d));
    check(snd_ready == 1'b0, "R7 not free before read", 64'(snd_ready), 64'h0);
    read_and_count(n);
    check(n == SYNC, "R7 sender edges to ready", 64'(n), 64'(SYNC));
  endtask

  task automatic t_blocked;
    int n;
    logic [W-1:0] a = 36'h1_2345_6789;
    send_word(a);
    snd_valid = 1'b1;
    snd_data  = 36'hE_DCBA_9876;
    for (int i = 0; i < 3; i++) begin
      @(posedge snd_clk); #0.2;
      check(snd_ready == 1'b0, "R3 still blocked", 64'(snd_ready), 64'h0);
    end
    snd_valid = 1'b0;
    wait_valid(n);
    check(rcv_data == a, "R3 blocked write ignored", 64'(rcv_data), 64'(a));
    read_and_count(n);
    check(snd_ready == 1'b1, "R3 free after read", 64'(snd_ready), 64'h1);
  endtask

  task automatic t_idle_read;
    @(posedge rcv_clk); #0.2;
    rcv_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge rcv_clk); #0.2;
    end
    rcv_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge snd_clk); #0.2;
    end
    check(rcv_valid == 1'b0 && snd_ready == 1'b1, "R8 idle read no effect",
          {62'b0, rcv_valid, snd_ready}, 64'h1);
    t_xfer(36'h0_0000_0001);
  endtask

  task automatic t_reset_mid;
    int n;
    send_word(36'hC_0FFE_E000);
    wait_valid(n);
    #1;
    rst_n = 1'b0;
    #1;
    check(rcv_full_n == 1'b1 && snd_ready == 1'b1, "R9 reset discards word",
          {62'b0, rcv_full_n, snd_ready}, 64'h3);
    @(posedge snd_clk); #0.2;
    rst_n = 1'b1;
    t_xfer(36'h5_A5A5_A5A5);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_xfer(36'h0_0000_0000);
    t_xfer(36'hF_FFFF_FFFF);
    t_xfer(36'hA_AAAA_AAAA);
    t_blocked();
    t_idle_read();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule